// File: doc/BRIEF.md
# Page Program Buffer with In-Page Address Wrap

This block sits behind the serial command decoder of a non-volatile memory. Once the decoder has taken in a write opcode and its address, it hands the start address to the block and then delivers each completed data byte with a one-cycle strobe. The block stores every byte in a one-page staging buffer of 256 bytes. Only the low 8 address bits advance from byte to byte, so a command that sends more bytes than remain in the page continues at offset 0 of the same page and replaces bytes loaded earlier.

When chip select goes high, the decoder reports a frame end, the number of whole bytes received, and the number of bits left over after the last whole byte. A separate permission input carries the result of protection checking. The block starts a self-timed program cycle only when the frame contains at least one whole byte, no partial byte, and permission. During that cycle it reports busy. It copies each loaded offset once, in ascending order, into the backing array through a write port, and leaves untouched offsets as they were. In the last busy cycle it pulses a request to clear the write-enable latch. Commands that arrive while busy are ignored.

Top module: `page_prog_buffer`

## Requirements
- R1: In reset and in the first cycle after it, busy, wr_en and wel_clr are all 0.
- R2: The first data byte of a command goes to the page offset given by start_addr[7:0]. Each later byte goes to the previous offset plus 1, modulo 256. Every commit write carries wr_addr[16:8] equal to start_addr[16:8] of that command.
- R3: When more than 256 bytes are loaded, an offset that receives several bytes commits the value of the last byte it received.
- R4: Each offset loaded by the command is written exactly once, with its byte, in ascending offset order. No write occurs to an offset that was not loaded, and wr_en is high only while busy is high.
- R5: A frame end with frame_bit_rem = 0, frame_bytes != 0 and commit_allow = 1 sets busy in the next cycle.
- R6: A frame end with frame_bit_rem != 0, with frame_bytes = 0, or with commit_allow = 0 starts no program cycle. Busy stays 0 and no write occurs.
- R7: Busy stays high for exactly max(PROG_CYCLES, 256) consecutive cycles.
- R8: wel_clr pulses for one cycle, once per program cycle, in the last cycle in which busy is high.
- R9: start_valid, byte_valid and frame_end asserted while busy have no effect. The committed bytes and the busy length stay those of the command already in progress.
- R10: A byte strobe in the same cycle as the frame end is loaded and committed.
- R11: A frame end with no preceding start_valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start address of a write command is valid |
| start_addr | input | ADDR_W | Start byte address; the top bits select the page |
| byte_valid | input | 1 | One completed data byte is present |
| byte_data | input | DATA_W | Data byte |
| frame_end | input | 1 | Chip select has risen |
| frame_bytes | input | CNT_W | Whole data bytes received in the frame |
| frame_bit_rem | input | $clog2(DATA_W) | Bits left over after the last whole byte |
| commit_allow | input | 1 | Protection checks allow the write |
| busy | output | 1 | Program cycle in progress |
| wr_en | output | 1 | Write strobe to the backing array |
| wr_addr | output | ADDR_W | Backing-array write address |
| wr_data | output | DATA_W | Backing-array write data |
| wel_clr | output | 1 | Request to clear the write-enable latch |

## Verification
Two pairs of functions can fall in the same cycle. The final byte strobe can coincide with the frame end, so one edge both loads that byte and launches the program cycle. The bench drives this directly and requires the byte to be committed. With the program length set to exactly one page, the commit write to offset 255 falls in the same cycle as the wel_clr pulse. A full-page command starting at offset 255 provokes this, and the bench judges it by the captured write data, the single wel_clr pulse and the exact busy length.

// File: rtl/pb_pkg.sv
package pb_pkg;

  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_LOAD = 2'd1,
    PB_PROG = 2'd2
  } pb_state_e;

  // a frame may program only if it ended on a byte boundary, carried data and was allowed
  function automatic logic frame_commits(input logic whole_bytes,
                                         input logic any_bytes,
                                         input logic allowed);
    return whole_bytes & any_bytes & allowed;
  endfunction

endpackage

// File: rtl/pb_page_store.sv
module pb_page_store #(
  parameter int PAGE_BYTES = 256,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              we,
  input  logic [OFF_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rdirty
);

  logic [DATA_W-1:0]     mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     dirty_q <= '0;
    else if (clear) dirty_q <= '0;
    else if (we)    dirty_q[waddr] <= 1'b1;
  end

  assign rdata  = mem[raddr];
  assign rdirty = dirty_q[raddr];

endmodule

// File: rtl/pb_prog_timer.sv
module pb_prog_timer #(
  parameter int PAGE_BYTES = 256,
  parameter int TOTAL      = 256,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CW        = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             active,
  output logic             scan_on,
  output logic [OFF_W-1:0] idx,
  output logic             last
);

  localparam logic [CW-1:0] LAST_C = CW'(TOTAL - 1);
  localparam logic [CW-1:0] PAGE_C = CW'(PAGE_BYTES);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (go) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end
    end else if (cnt_q == LAST_C) begin
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active  = act_q;
  assign scan_on = act_q && (cnt_q < PAGE_C);
  assign idx     = cnt_q[OFF_W-1:0];
  assign last    = act_q && (cnt_q == LAST_C);

endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 256,
  parameter int CNT_W       = 16,
  parameter int PROG_CYCLES = 1000,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int REM_W      = $clog2(DATA_W),
  localparam int T_TOTAL    = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  frame_bytes,
  input  logic [REM_W-1:0]  frame_bit_rem,
  input  logic              commit_allow,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wel_clr
);
  import pb_pkg::*;

  localparam int PAGE_W = ADDR_W - OFF_W;

  // offset inside the page advances and wraps; page bits never move
  function automatic logic [OFF_W-1:0] step_off(input logic [OFF_W-1:0] o);
    return o + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PAGE_W-1:0] pg,
                                                  input logic [OFF_W-1:0]  off);
    return {pg, off};
  endfunction

  pb_state_e         state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  ptr_q;

  // named internal events
  logic              load_start;
  logic              load_byte;
  logic              prog_go;
  logic              frame_drop;
  logic              prog_last;
  logic              scan_on;
  logic              timer_active;
  logic [OFF_W-1:0]  scan_idx;
  logic [DATA_W-1:0] buf_rdata;
  logic              buf_dirty;

  assign load_start = (state_q == PB_IDLE) && start_valid;
  assign load_byte  = (state_q == PB_LOAD) && byte_valid;
  assign prog_go    = (state_q == PB_LOAD) && frame_end &&
                      frame_commits(frame_bit_rem == '0, |frame_bytes, commit_allow);
  assign frame_drop = (state_q == PB_LOAD) && frame_end && !prog_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PB_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        PB_IDLE: begin
          if (load_start) begin
            state_q <= PB_LOAD;
            page_q  <= start_addr[ADDR_W-1:OFF_W];
            ptr_q   <= start_addr[OFF_W-1:0];
          end
        end
        PB_LOAD: begin
          if (load_byte) ptr_q <= step_off(ptr_q);
          if (prog_go)         state_q <= PB_PROG;
          else if (frame_drop) state_q <= PB_IDLE;
        end
        PB_PROG: begin
          if (prog_last) state_q <= PB_IDLE;
        end
        default: state_q <= PB_IDLE;
      endcase
    end
  end

  pb_page_store #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (load_start),
    .we     (load_byte),
    .waddr  (ptr_q),
    .wdata  (byte_data),
    .raddr  (scan_idx),
    .rdata  (buf_rdata),
    .rdirty (buf_dirty)
  );

  pb_prog_timer #(
    .PAGE_BYTES (PAGE_BYTES),
    .TOTAL      (T_TOTAL)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (prog_go),
    .active  (timer_active),
    .scan_on (scan_on),
    .idx     (scan_idx),
    .last    (prog_last)
  );

  assign busy    = (state_q == PB_PROG) && timer_active;
  assign wr_en   = scan_on && buf_dirty;
  assign wr_addr = join_addr(page_q, scan_idx);
  assign wr_data = buf_rdata;
  assign wel_clr = prog_last;

endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int ADDR_W = 17,
  parameter int OFF_W  = 8,
  parameter int REM_W  = 3,
  parameter int TOTAL  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wel_clr,
  input logic              frame_end,
  input logic [REM_W-1:0]  frame_bit_rem,
  input logic              prog_go
);

  localparam int RW = $clog2(TOTAL + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_wr_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_scan_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr[OFF_W-1:0] > $past(wr_addr[OFF_W-1:0])));

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> $stable(wr_addr[ADDR_W-1:OFF_W]));

  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_go));

  assert_partial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame_bit_rem != '0 && !busy) |=> !busy);

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RW'(TOTAL)));

  assert_wel_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel_clr) |=> busy);

endmodule

bind page_prog_buffer pb_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .REM_W  (REM_W),
  .TOTAL  (T_TOTAL)
) u_pb_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wel_clr       (wel_clr),
  .frame_end     (frame_end),
  .frame_bit_rem (frame_bit_rem),
  .prog_go       (prog_go)
);

// File: tb/tb_page_prog_buffer.sv
module tb_page_prog_buffer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 17;
  localparam int DATA_W     = 8;
  localparam int PAGE       = 256;
  localparam int CNT_W      = 16;
  localparam int PROG_CYC   = 256;
  localparam int TOTAL      = (PROG_CYC > PAGE) ? PROG_CYC : PAGE;

  typedef struct packed {
    logic [16:0] addr;
    logic [15:0] n;
    logic [2:0]  rem;
    logic        allow;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{17'h00310, 16'd4,   3'd0, 1'b1},
    '{17'h1A2FE, 16'd5,   3'd0, 1'b1},
    '{17'h04400, 16'd300, 3'd0, 1'b1},
    '{17'h0FFFF, 16'd256, 3'd0, 1'b1},
    '{17'h00520, 16'd3,   3'd3, 1'b1},
    '{17'h00640, 16'd2,   3'd0, 1'b0},
    '{17'h00780, 16'd0,   3'd0, 1'b1},
    '{17'h00890, 16'd7,   3'd0, 1'b1}
  };
  localparam string TAGS [NV] = '{"R2", "R2", "R3", "R4", "R6", "R6", "R6", "R5"};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_valid = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              byte_valid = 1'b0;
  logic [DATA_W-1:0] byte_data = '0;
  logic              frame_end = 1'b0;
  logic [CNT_W-1:0]  frame_bytes = '0;
  logic [2:0]        frame_bit_rem = '0;
  logic              commit_allow = 1'b0;
  logic              busy, wr_en, wel_clr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  page_prog_buffer #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PAGE_BYTES (PAGE),
    .CNT_W (CNT_W), .PROG_CYCLES (PROG_CYC)
  ) dut (
    .clk (clk), .rst_n (rst_n), .start_valid (start_valid), .start_addr (start_addr),
    .byte_valid (byte_valid), .byte_data (byte_data), .frame_end (frame_end),
    .frame_bytes (frame_bytes), .frame_bit_rem (frame_bit_rem),
    .commit_allow (commit_allow), .busy (busy), .wr_en (wr_en),
    .wr_addr (wr_addr), .wr_data (wr_data), .wel_clr (wel_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] exp_data [PAGE];
  bit         exp_dirty [PAGE];
  logic [8:0] exp_page;
  logic [7:0] got_data [PAGE];
  int         got_hits [PAGE];
  int         busy_cnt, wel_cnt;
  bit         page_bad;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 13 + (i / 256) * 91) & 255);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (wel_clr) wel_cnt++;
      if (wr_en) begin
        got_data[wr_addr[7:0]] = wr_data;
        got_hits[wr_addr[7:0]]++;
        if (wr_addr[16:8] != exp_page) page_bad = 1;
      end
    end
  end

  task automatic clear_capture();
    for (int k = 0; k < PAGE; k++) begin
      got_hits[k] = 0;
      got_data[k] = '0;
    end
    busy_cnt = 0;
    wel_cnt  = 0;
    page_bad = 0;
  endtask

  // load the reference page: later bytes overwrite earlier ones at the same offset
  task automatic model_frame(input logic [16:0] addr, input int n, input int seed);
    for (int k = 0; k < PAGE; k++) exp_dirty[k] = 0;
    exp_page = addr[16:8];
    for (int i = 0; i < n; i++) begin
      exp_data[(int'(addr[7:0]) + i) % PAGE] = pat(seed, i);
      exp_dirty[(int'(addr[7:0]) + i) % PAGE] = 1;
    end
  endtask

  task automatic go_frame(input logic [16:0] addr, input int n, input logic [2:0] rem,
                          input logic allow, input int seed, input bit tail);
    clear_capture();
    model_frame(addr, n, seed);
    @(negedge clk);
    start_valid = 1'b1;
    start_addr  = addr;
    @(negedge clk);
    start_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1;
      byte_data  = pat(seed, i);
      if (tail && i == n - 1) begin
        frame_end     = 1'b1;
        frame_bytes   = CNT_W'(n);
        frame_bit_rem = rem;
        commit_allow  = allow;
      end
      @(negedge clk);
    end
    byte_valid = 1'b0;
    if (!(tail && n > 0)) begin
      frame_end     = 1'b1;
      frame_bytes   = CNT_W'(n);
      frame_bit_rem = rem;
      commit_allow  = allow;
      @(negedge clk);
    end
    frame_end = 1'b0;
  endtask

  task automatic finish_frame(input bit expect_prog, input string tag);
    int bad;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(busy_cnt == (expect_prog ? TOTAL : 0), expect_prog ? "R7 busy length" : "R6 busy length",
          busy_cnt, expect_prog ? TOTAL : 0);
    check(wel_cnt == (expect_prog ? 1 : 0), "R8 wel_clr pulses", wel_cnt, expect_prog ? 1 : 0);
    bad = 0;
    for (int k = 0; k < PAGE; k++) begin
      if (expect_prog && exp_dirty[k]) begin
        if (got_hits[k] != 1 || got_data[k] != exp_data[k]) begin
          if (bad == 0) $display("  offset %0d: hits=%0d data=%0h want=%0h", k, got_hits[k], got_data[k], exp_data[k]);
          bad++;
        end
      end else if (got_hits[k] != 0) begin
        if (bad == 0) $display("  offset %0d: unexpected write", k);
        bad++;
      end
    end
    check(bad == 0, {tag, " R4 committed bytes"}, bad, 0);
    check(!page_bad, "R2 page bits", page_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_capture();
    exp_page = '0;
    repeat (3) @(negedge clk);
    check(busy == 0 && wr_en == 0 && wel_clr == 0, "R1 outputs in reset", {busy, wr_en, wel_clr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && wr_en == 0 && wel_clr == 0, "R1 outputs after reset", {busy, wr_en, wel_clr}, 0);

    for (int v = 0; v < NV; v++) begin
      go_frame(VECS[v].addr, int'(VECS[v].n), VECS[v].rem, VECS[v].allow, v + 1, 1'b0);
      finish_frame((VECS[v].n != 0) && (VECS[v].rem == 0) && VECS[v].allow, TAGS[v]);
    end

    // R10: last byte coincides with the frame end
    go_frame(17'h0A3F0, 6, 3'd0, 1'b1, 20, 1'b1);
    finish_frame(1'b1, "R10");

    // R9: a whole command pushed in while busy must leave the running one untouched
    go_frame(17'h05000, 4, 3'd0, 1'b1, 30, 1'b0);
    repeat (5) @(negedge clk);
    check(busy == 1, "R5 busy after valid frame", busy, 1);
    start_valid = 1'b1; start_addr = 17'h1FF00;
    byte_valid = 1'b1; byte_data = 8'hAA;
    frame_end = 1'b1; frame_bytes = 16'd1; frame_bit_rem = 3'd0; commit_allow = 1'b1;
    @(negedge clk);
    start_valid = 1'b0; byte_valid = 1'b0; frame_end = 1'b0;
    finish_frame(1'b1, "R9");

    // R11: frame end with no start address
    clear_capture();
    for (int k = 0; k < PAGE; k++) exp_dirty[k] = 0;
    frame_end = 1'b1; frame_bytes = 16'd2; frame_bit_rem = 3'd0; commit_allow = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    repeat (4) @(negedge clk);
    check(busy_cnt == 0 && busy == 0, "R11 stray frame end", busy_cnt, 0);
    finish_frame(1'b0, "R11");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule